// File: doc/BRIEF.md
# Group Write Transaction Slave Receiver

This block is the byte-level receive engine of a management-bus slave that takes part in multi-device group writes. A bit-level front end (outside this block) samples the two bus wires, detects START, REPEATED START and STOP conditions, and assembles received bytes. The receiver is given those events and bytes. It decides, byte by byte, whether the slave acknowledges. It stages the command code and data bytes of the one sub-packet addressed to it. When enabled, it checks that sub-packet's trailing checksum byte.

A group write is a chain of sub-packets, one per target device, separated by REPEATED START and closed by a single STOP. Whatever this device received stays staged, and does not reach its command outputs, until the closing STOP arrives. At that point a one-cycle execute strobe is raised together with the new command, provided nothing in the transaction was flagged. The surrounding logic acts on the strobe. The strobes of every device on the bus therefore line up on the same bus event.

Top module: `grpcmd_rx`

## Requirements
- R1: The address byte carries the 7-bit device address in bits 7:1 and the direction in bit 0 (0 = write). An address byte equal to `own_addr` with bit 0 low is acknowledged. Any other address is refused, and so is every later byte of that sub-packet. Each decision appears on `ack_valid`/`ack` (1 = acknowledge) in the cycle after `byte_valid`.
- R2: An address byte with bit 0 high (read) is never acknowledged, even when it matches `own_addr`, and it never leads to an execution.
- R3: In this device's sub-packet, the first byte after the address is the command code and the following bytes are data. At execution, data byte k appears on `cmd_data[8k+7:8k]` (first received byte lowest). `cmd_len` gives the number of data bytes, and data bytes at index `cmd_len` and above read as zero.
- R4: `exec_stb` is high for exactly one cycle, the cycle after `ev_stop`, and only when a valid command is pending for this device.
- R5: `cmd_code`, `cmd_data` and `cmd_len` change only in the cycle in which `exec_stb` is high. A sub-packet that ends at REPEATED START leaves them unchanged.
- R6: When `pec_en` is high, the last byte of the sub-packet is a checksum: CRC-8, polynomial x^8+x^2+x+1 (0x07), initial value 0, no final inversion, each byte processed MSB first. It covers the address byte, the command and the data. A mismatch sets `err_flag`, and the command is not executed.
- R7: The checksum covers only this device's own sub-packet. Accumulation restarts at every START and REPEATED START, so bytes of other sub-packets do not affect the result.
- R8: A second sub-packet to this device within one transaction sets `err_flag`, and neither sub-packet is executed.
- R9: Bytes beyond the capacity (the command, `MAX_DATA` data bytes and the checksum byte when enabled) are refused. The sub-packet is then flagged in `err_flag` and not executed. A sub-packet too short to hold the command (and the checksum when enabled) is flagged the same way.
- R10: `bus_timeout` or a START discards any pending command and clears `err_flag`. A later STOP then produces no strobe.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | This device's bus address |
| pec_en | input | 1 | Checksum byte expected at the end of each sub-packet |
| bus_timeout | input | 1 | Bus timeout indication; aborts the transaction |
| ev_start | input | 1 | START condition detected (one cycle) |
| ev_rstart | input | 1 | REPEATED START condition detected (one cycle) |
| ev_stop | input | 1 | STOP condition detected (one cycle) |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte, bit 7 was first on the wire |
| ack_valid | output | 1 | An acknowledge decision is present |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| exec_stb | output | 1 | One-cycle execute strobe after the closing STOP |
| err_flag | output | 1 | Protocol or checksum error in the current transaction |
| cmd_code | output | 8 | Command code of the last executed command |
| cmd_data | output | 8*MAX_DATA | Data bytes of the last executed command, first byte lowest |
| cmd_len | output | clog2(MAX_DATA+1) | Number of valid data bytes in cmd_data |

## Verification
Group writes of one to four sub-packets are generated with mixed addresses (own write, own read, foreign). Data lengths run from zero to one past capacity, with the checksum on or off and occasionally corrupted. The expected acknowledge pattern, strobe and outputs are computed by a bench model. Mixing foreign sub-packets after this device's own sub-packet distinguishes a checksum that stops at REPEATED START from one that keeps running. Checking the outputs right after REPEATED START distinguishes held-back commands from early ones. Directed cases cover a repeated own address, a read bit, a short packet with a checksum, a timeout and a START that cuts a transaction short; each must suppress the strobe.

// File: rtl/grpcmd_pkg.sv
// Shared definitions for the group write receiver.
// Assumes bytes are presented MSB-first as received on the wire.
package grpcmd_pkg;

    // Checksum generator polynomial x^8+x^2+x+1, implicit x^8 term dropped.
    localparam logic [7:0] CRC8_POLY = 8'h07;

    // Receive state of the current sub-packet.
    typedef enum logic [1:0] {
        RX_IDLE,   // outside a transaction
        RX_ADDR,   // next byte is an address byte
        RX_MINE,   // inside this device's write sub-packet
        RX_PASS    // inside a sub-packet not taken by this device
    } rx_state_e;

    // Advance a CRC-8 over one byte, most significant bit first.
    function automatic logic [7:0] crc8_next(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC8_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/grpcmd_crc8.sv
// Running CRC-8 over the bytes of one sub-packet.
// Assumes clr and upd are never high together; clr wins if they are.
module grpcmd_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc_q
);
    import grpcmd_pkg::*;

    // Restart at every sub-packet boundary, fold in each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= 8'h00;
        end else if (upd) begin
            crc_q <= crc8_next(crc_q, din);
        end
    end

endmodule

// File: rtl/grpcmd_frame.sv
// Sub-packet framing: tracks address/command/data position, decides the
// acknowledge for each byte and reports when this device's sub-packet ends.
// Assumes at most one of the event and byte inputs is high per cycle; if
// several are, timeout beats START beats REPEATED START beats STOP beats byte.
module grpcmd_frame #(
    parameter int MAX_DATA = 2,
    parameter int IDX_W    = $clog2(MAX_DATA + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       own_addr,
    input  logic             pec_en,
    input  logic             bus_timeout,
    input  logic             ev_start,
    input  logic             ev_rstart,
    input  logic             ev_stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             ack_valid,
    output logic             ack,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic             cap_vld,
    output logic [IDX_W-1:0] cap_idx,
    output logic             sp_close,
    output logic [IDX_W-1:0] sp_len,
    output logic             sp_ovf,
    output logic             txn_stop,
    output logic             txn_flush
);
    import grpcmd_pkg::*;

    localparam logic [IDX_W-1:0] CNT_MAX  = '1;
    localparam logic [IDX_W-1:0] LIM_BARE = IDX_W'(MAX_DATA + 1);
    localparam logic [IDX_W-1:0] LIM_PEC  = IDX_W'(MAX_DATA + 2);

    rx_state_e        state_q;
    logic [IDX_W-1:0] cnt_q;
    logic             ovf_q;
    logic [IDX_W-1:0] cap_lim;
    logic             byte_go;
    logic             boundary;
    logic             in_room;

    // Qualify events by priority and size the sub-packet capacity.
    always_comb begin
        boundary  = ev_start | ev_rstart;
        byte_go   = byte_valid & ~bus_timeout & ~boundary & ~ev_stop;
        cap_lim   = pec_en ? LIM_PEC : LIM_BARE;
        in_room   = (cnt_q < cap_lim);
        txn_flush = bus_timeout | ev_start;
        txn_stop  = ev_stop & ~txn_flush & ~ev_rstart;
        sp_close  = (state_q == RX_MINE) & ~txn_flush & (ev_rstart | ev_stop);
        crc_clr   = boundary;
        crc_upd   = byte_go & ((state_q == RX_ADDR) | (state_q == RX_MINE));
        cap_vld   = byte_go & (state_q == RX_MINE) & in_room;
        cap_idx   = cnt_q;
        sp_len    = cnt_q;
        sp_ovf    = ovf_q;
    end

    // Walk address, command and data positions; register the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            if (bus_timeout) begin
                state_q <= RX_IDLE;
            end else if (boundary) begin
                state_q <= RX_ADDR;
                cnt_q   <= '0;
                ovf_q   <= 1'b0;
            end else if (ev_stop) begin
                state_q <= RX_IDLE;
            end else if (byte_valid) begin
                case (state_q)
                    RX_ADDR: begin
                        ack_valid <= 1'b1;
                        if (byte_data[7:1] == own_addr && !byte_data[0]) begin
                            state_q <= RX_MINE;
                            ack     <= 1'b1;
                        end else begin
                            state_q <= RX_PASS;
                        end
                    end
                    RX_MINE: begin
                        ack_valid <= 1'b1;
                        if (in_room) ack <= 1'b1;
                        else         ovf_q <= 1'b1;
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end
                    RX_PASS: ack_valid <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R1: bytes of a sub-packet for another device are refused
    a_r1_pass_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && state_q == RX_PASS) |=> (ack_valid && !ack));

    // R2: a read address is refused
    a_r2_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && state_q == RX_ADDR && byte_data[0]) |=> (ack_valid && !ack));

    // R9: bytes past capacity are refused
    a_r9_over_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_go && state_q == RX_MINE && !in_room) |=> (ack_valid && !ack));

endmodule

// File: rtl/grpcmd_commit.sv
// Staging and commit: holds the captured command until the closing STOP,
// validates length, checksum and uniqueness, and drives the execute strobe
// together with the visible command registers.
// Assumes the checksum value presented at sp_close covers the whole sub-packet.
module grpcmd_commit #(
    parameter int MAX_DATA = 2,
    parameter int IDX_W    = $clog2(MAX_DATA + 4),
    parameter int LEN_W    = $clog2(MAX_DATA + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pec_en,
    input  logic                  cap_vld,
    input  logic [IDX_W-1:0]      cap_idx,
    input  logic [7:0]            cap_byte,
    input  logic                  sp_close,
    input  logic [IDX_W-1:0]      sp_len,
    input  logic                  sp_ovf,
    input  logic [7:0]            crc_q,
    input  logic                  txn_stop,
    input  logic                  txn_flush,
    output logic                  exec_stb,
    output logic                  err_flag,
    output logic [7:0]            cmd_code,
    output logic [8*MAX_DATA-1:0] cmd_data,
    output logic [LEN_W-1:0]      cmd_len
);
    localparam logic [IDX_W-1:0] MAX_D = IDX_W'(MAX_DATA);

    logic [7:0]            stage_cmd;
    logic [7:0]            stage_dat [MAX_DATA];
    logic                  pend_q;
    logic                  seen_q;
    logic [LEN_W-1:0]      plen_q;
    logic [IDX_W-1:0]      ovh;
    logic [IDX_W-1:0]      body_len;
    logic                  close_good;
    logic                  pend_n;
    logic [LEN_W-1:0]      plen_n;
    logic [8*MAX_DATA-1:0] dat_masked;

    // Capture the command byte into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_cmd <= 8'h00;
        end else if (cap_vld && cap_idx == '0) begin
            stage_cmd <= cap_byte;
        end
    end

    for (genvar k = 0; k < MAX_DATA; k++) begin : g_stage
        // Capture data byte k into its staging slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_dat[k] <= 8'h00;
            end else if (cap_vld && cap_idx == IDX_W'(k + 1)) begin
                stage_dat[k] <= cap_byte;
            end
        end
    end

    // Judge the closing sub-packet and form the pending state it leaves.
    always_comb begin
        ovh        = pec_en ? IDX_W'(2) : IDX_W'(1);
        body_len   = sp_len - ovh;
        close_good = (sp_len >= ovh) && (body_len <= MAX_D) && !sp_ovf &&
                     (!pec_en || crc_q == 8'h00) && !seen_q;
        pend_n     = pend_q;
        plen_n     = plen_q;
        if (sp_close) begin
            pend_n = close_good;
            if (close_good) plen_n = LEN_W'(body_len);
        end
        for (int k = 0; k < MAX_DATA; k++) begin
            dat_masked[8*k +: 8] = (int'(plen_n) > k) ? stage_dat[k] : 8'h00;
        end
    end

    // Track pending, duplicate and error state; commit at the closing STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            seen_q   <= 1'b0;
            plen_q   <= '0;
            exec_stb <= 1'b0;
            err_flag <= 1'b0;
            cmd_code <= 8'h00;
            cmd_data <= '0;
            cmd_len  <= '0;
        end else begin
            exec_stb <= 1'b0;
            if (txn_flush) begin
                pend_q   <= 1'b0;
                seen_q   <= 1'b0;
                err_flag <= 1'b0;
            end else begin
                if (sp_close) begin
                    seen_q <= 1'b1;
                    if (!close_good) err_flag <= 1'b1;
                end
                plen_q <= plen_n;
                if (txn_stop) begin
                    exec_stb <= pend_n;
                    pend_q   <= 1'b0;
                    seen_q   <= 1'b0;
                    if (pend_n) begin
                        cmd_code <= stage_cmd;
                        cmd_data <= dat_masked;
                        cmd_len  <= plen_n;
                    end
                end else begin
                    pend_q <= pend_n;
                end
            end
        end
    end

    // R4: the strobe lasts one cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb);

    // R4: the strobe follows a STOP
    a_r4_strobe_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> $past(txn_stop));

    // R5: visible command registers move only with the strobe
    a_r5_held_back: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_stb |-> ($stable(cmd_code) && $stable(cmd_data) && $stable(cmd_len)));

    // R6: a checksum mismatch flags and suppresses execution
    a_r6_bad_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_close && pec_en && crc_q != 8'h00) |=> (err_flag && !exec_stb));

    // R8: a repeated own sub-packet flags and suppresses execution
    a_r8_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_close && seen_q) |=> (err_flag && !exec_stb));

    // R10: a flush clears the error flag
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        txn_flush |=> (!err_flag && !exec_stb));

endmodule

// File: rtl/grpcmd_rx.sv
// Group write slave receiver top: framing, running checksum and commit.
// Assumes a bit-level front end delivering single-cycle condition events
// and whole bytes; acknowledges are driven back to that front end.
module grpcmd_rx #(
    parameter int MAX_DATA = 2,
    parameter int LEN_W    = $clog2(MAX_DATA + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [6:0]            own_addr,
    input  logic                  pec_en,
    input  logic                  bus_timeout,
    input  logic                  ev_start,
    input  logic                  ev_rstart,
    input  logic                  ev_stop,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    output logic                  ack_valid,
    output logic                  ack,
    output logic                  exec_stb,
    output logic                  err_flag,
    output logic [7:0]            cmd_code,
    output logic [8*MAX_DATA-1:0] cmd_data,
    output logic [LEN_W-1:0]      cmd_len
);
    localparam int IDX_W = $clog2(MAX_DATA + 4);

    logic             crc_clr;
    logic             crc_upd;
    logic [7:0]       crc_q;
    logic             cap_vld;
    logic [IDX_W-1:0] cap_idx;
    logic             sp_close;
    logic [IDX_W-1:0] sp_len;
    logic             sp_ovf;
    logic             txn_stop;
    logic             txn_flush;

    grpcmd_frame #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W)) frame_i (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .pec_en(pec_en),
        .bus_timeout(bus_timeout), .ev_start(ev_start), .ev_rstart(ev_rstart),
        .ev_stop(ev_stop), .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_valid(ack_valid), .ack(ack), .crc_clr(crc_clr), .crc_upd(crc_upd),
        .cap_vld(cap_vld), .cap_idx(cap_idx), .sp_close(sp_close),
        .sp_len(sp_len), .sp_ovf(sp_ovf), .txn_stop(txn_stop), .txn_flush(txn_flush)
    );

    grpcmd_crc8 crc_i (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
        .din(byte_data), .crc_q(crc_q)
    );

    grpcmd_commit #(.MAX_DATA(MAX_DATA), .IDX_W(IDX_W), .LEN_W(LEN_W)) commit_i (
        .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .cap_vld(cap_vld),
        .cap_idx(cap_idx), .cap_byte(byte_data), .sp_close(sp_close),
        .sp_len(sp_len), .sp_ovf(sp_ovf), .crc_q(crc_q), .txn_stop(txn_stop),
        .txn_flush(txn_flush), .exec_stb(exec_stb), .err_flag(err_flag),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_len(cmd_len)
    );

endmodule

// File: tb/grpcmd_rx_tb_top.sv
// Bench for the group write receiver: directed corners plus seeded random
// group transactions, compared against a bench-side model.
module grpcmd_rx_tb_top;
    localparam int         MAX_DATA = 2;
    localparam logic [6:0] OWN      = 7'h2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pec_en = 1'b0;
    logic        bus_timeout = 1'b0;
    logic        ev_start = 1'b0;
    logic        ev_rstart = 1'b0;
    logic        ev_stop = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        ack_valid, ack, exec_stb, err_flag;
    logic [7:0]  cmd_code;
    logic [15:0] cmd_data;
    logic [1:0]  cmd_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the transaction
    bit          m_pend, m_seen, m_err;
    logic [7:0]  m_cmd, m_scmd;
    logic [15:0] m_data, m_sdata;
    logic [1:0]  m_len, m_slen;

    grpcmd_rx #(.MAX_DATA(MAX_DATA)) dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN), .pec_en(pec_en),
        .bus_timeout(bus_timeout), .ev_start(ev_start), .ev_rstart(ev_rstart),
        .ev_stop(ev_stop), .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_valid(ack_valid), .ack(ack), .exec_stb(exec_stb), .err_flag(err_flag),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_len(cmd_len)
    );

    always #5 clk = ~clk;

    // bit-serial CRC-8, polynomial 0x07, MSB first
    function automatic logic [7:0] ref_crc(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c = crc;
        for (int i = 7; i >= 0; i--) begin
            logic fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: ev_start = 1'b1;
            1: ev_rstart = 1'b1;
            2: ev_stop = 1'b1;
            default: bus_timeout = 1'b1;
        endcase
        @(negedge clk);
        ev_start = 1'b0; ev_rstart = 1'b0; ev_stop = 1'b0; bus_timeout = 1'b0;
    endtask

    task automatic send_b(input logic [7:0] b, input bit exp_ack, input string req);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        chk({req, " ack_valid"}, 32'(ack_valid), 32'd1);
        chk({req, " ack"}, 32'(ack), 32'(exp_ack));
    endtask

    // open a transaction (first) or the next sub-packet
    task automatic open_sp(input bit first);
        if (first) begin
            pulse(0);
            m_pend = 0; m_seen = 0; m_err = 0;
        end else begin
            pulse(1);
            chk("R5 no strobe at repeated start", 32'(exec_stb), 32'd0);
            chk("R5 command held at repeated start", 32'(cmd_code), 32'(m_cmd));
            chk("R5 data held at repeated start", 32'(cmd_data), 32'(m_data));
        end
    endtask

    // send one sub-packet; pec byte appended when add_pec, xored with flip
    task automatic send_sp(input logic [6:0] addr, input bit rd, input logic [7:0] cmd,
                           input int nd, input logic [23:0] dat,
                           input bit add_pec, input logic [7:0] flip);
        bit         mine = (addr == OWN) && !rd;
        logic [7:0] abyte = {addr, rd};
        logic [7:0] crc = ref_crc(8'h00, abyte);
        logic [7:0] b;
        int         cap = 1 + MAX_DATA + (pec_en ? 1 : 0);
        int         ovh = pec_en ? 2 : 1;
        int         n = 1 + nd + (add_pec ? 1 : 0);
        bit         good;
        send_b(abyte, mine, rd ? "R2 read address" : "R1 address");
        for (int i = 0; i < n; i++) begin
            if (i == 0)              b = cmd;
            else if (i <= nd)        b = dat[8*(i-1) +: 8];
            else                     b = crc ^ flip;
            crc = ref_crc(crc, b);
            send_b(b, mine && (i < cap), !mine ? "R1 foreign byte" :
                   (i >= cap) ? "R9 past capacity" : "R3 own byte");
        end
        if (mine) begin
            good = (n >= ovh) && (n - ovh <= MAX_DATA) && (!pec_en || crc == 8'h00) && !m_seen;
            if (!good) begin
                m_err = 1; m_pend = 0;
            end else begin
                m_pend = 1; m_scmd = cmd; m_slen = 2'(n - ovh); m_sdata = '0;
                for (int k = 0; k < MAX_DATA; k++)
                    if (k < n - ovh) m_sdata[8*k +: 8] = dat[8*k +: 8];
            end
            m_seen = 1;
        end
    endtask

    task automatic do_timeout();
        pulse(3);
        m_pend = 0; m_seen = 0; m_err = 0;
    endtask

    task automatic close_txn(input string req);
        pulse(2);
        chk({req, " R4 strobe"}, 32'(exec_stb), 32'(m_pend));
        chk({req, " error flag"}, 32'(err_flag), 32'(m_err));
        if (m_pend) begin
            m_cmd = m_scmd; m_data = m_sdata; m_len = m_slen;
        end
        chk({req, " R3 command"}, 32'(cmd_code), 32'(m_cmd));
        chk({req, " R3 data"}, 32'(cmd_data), 32'(m_data));
        chk({req, " R3 length"}, 32'(cmd_len), 32'(m_len));
        @(negedge clk);
        chk({req, " R4 strobe one cycle"}, 32'(exec_stb), 32'd0);
        m_pend = 0; m_seen = 0;
    endtask

    function automatic logic [6:0] other_addr();
        logic [6:0] a;
        do a = 7'($urandom()); while (a == OWN);
        return a;
    endfunction

    function automatic logic [7:0] pec_of(input logic [7:0] a, input logic [7:0] c,
                                          input int nd, input logic [23:0] d);
        logic [7:0] r = ref_crc(ref_crc(8'h00, a), c);
        for (int i = 0; i < nd; i++) r = ref_crc(r, d[8*i +: 8]);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_cmd = 0; m_data = 0; m_len = 0; m_scmd = 0; m_sdata = 0; m_slen = 0;
        m_pend = 0; m_seen = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ack_valid", 32'(ack_valid), 0);
        chk("R11 exec_stb", 32'(exec_stb), 0);
        chk("R11 err_flag", 32'(err_flag), 0);
        chk("R11 cmd_code", 32'(cmd_code), 0);
        chk("R11 cmd_data", 32'(cmd_data), 0);
        chk("R11 cmd_len", 32'(cmd_len), 0);

        // R1/R3/R4 single own write, no checksum
        pec_en = 0;
        open_sp(1); send_sp(OWN, 0, 8'hA5, 2, 24'h00_3C_91, 0, 0);
        close_txn("R4 single");

        // R5/R7 own first with checksum, then a foreign sub-packet
        pec_en = 1;
        open_sp(1); send_sp(OWN, 0, 8'h21, 1, 24'h77, 1, 0);
        open_sp(0); send_sp(other_addr(), 0, 8'hFE, 2, 24'h00_13_57, 1, 8'h5A);
        close_txn("R7 scoped sum");

        // R2 own address with read bit
        open_sp(1); send_sp(OWN, 1, 8'h10, 1, 24'h1, 0, 0);
        close_txn("R2 read");

        // R6 corrupted checksum
        open_sp(1); send_sp(OWN, 0, 8'h30, 2, 24'h00_AB_CD, 1, 8'h04);
        close_txn("R6 bad sum");

        // R8 two sub-packets to this device
        open_sp(1); send_sp(OWN, 0, 8'h40, 1, 24'h11, 1, 0);
        open_sp(0); send_sp(OWN, 0, 8'h41, 1, 24'h22, 1, 0);
        close_txn("R8 repeat");

        // R9 overflow and too short
        pec_en = 0;
        open_sp(1); send_sp(OWN, 0, 8'h50, 3, 24'h33_22_11, 0, 0);
        close_txn("R9 overflow");
        pec_en = 1;
        open_sp(1); send_sp(OWN, 0, 8'h51, 0, 24'h0, 0, 0);
        close_txn("R9 short");

        // R10 timeout, then START, both discard the pending command
        open_sp(1); send_sp(OWN, 0, 8'h60, 1, 24'h44, 1, 0);
        open_sp(0); do_timeout();
        close_txn("R10 timeout");
        open_sp(1); send_sp(OWN, 0, 8'h61, 1, 24'h45, 1, 0);
        open_sp(1); send_sp(other_addr(), 0, 8'h62, 0, 24'h0, 1, 0);
        close_txn("R10 start");

        // seeded random group transactions
        for (int t = 0; t < 400; t++) begin
            int nsub = 1 + int'($urandom_range(3, 0));
            @(negedge clk);
            pec_en = $urandom_range(1, 0) == 1;
            for (int s = 0; s < nsub; s++) begin
                int          sel = int'($urandom_range(5, 0));
                logic [6:0]  a = (sel < 3) ? OWN : other_addr();
                bit          rd = (sel == 2);
                int          nd = int'($urandom_range(3, 0));
                logic [23:0] d = 24'($urandom());
                logic [7:0]  c = 8'($urandom());
                logic [7:0]  fl = ($urandom_range(7, 0) == 0) ? (8'h01 << $urandom_range(7, 0)) : 8'h00;
                bit          ap = pec_en;
                open_sp(s == 0);
                send_sp(a, rd, c, nd, d, ap, ap ? (pec_of({a, rd}, c, nd, d) ^ pec_of({a, rd}, c, nd, d) ^ fl) : 8'h00);
            end
            if ($urandom_range(15, 0) == 0) do_timeout();
            close_txn("R6 R8 R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule